// File: doc/BRIEF.md
# Address/Data Register Write Port with Pipe Mode

This block sits on the register write bus of a small control processor and turns writes to three special general registers into side-channel writes. Two of them hold addresses (a normal one and a user one); the third is a data port. Writing an address register stores the value and makes that register the one the data port draws its target from. Each data-port write then lands either in a flat register space or on a pipe register, and the address register steps forward on its own, so a sequence of data writes fills consecutive targets.

Whether a data write is a flat-space write or a pipe write depends on the current value of the selected address. Values up to 0xFFFF address the flat space and step by one. Larger values mean pipe mode: the pipe index is the top byte, the step adds one to that top byte only, and bit 18 freezes the address so the same pipe register is written repeatedly. Some pipe indices are "void": they carry no data and fire as soon as their address is written. One pipe register is a memory write stream. A write to it emits a 32-bit word to memory at a 64-bit address kept in two neighbouring pipe registers, and that address then moves forward by four bytes.

General registers other than the data port behave as plain storage with a read port; index 0 reads as zero.

Top module: `adp_port`

## Requirements
- R1: A write to general index 28 (normal address) or 29 (user address) stores the value, which reads back on the read port, and makes that register the source for subsequent data-port writes (index 30); reset selects the normal address register.
- R2: A data-port write whose selected address is at most 0xFFFF produces a flat-space write at the address's low 16 bits; above 0xFFFF it produces a pipe write whose index is address bits 31:24; the data is the written value in both cases.
- R3: In pipe mode only address bits 31:24 and 18 may be set when a data-port write occurs.
- R4: In pipe mode, with address bit 18 clear each data-port write adds 0x01000000 to the selected address register; with bit 18 set the address stays unchanged.
- R5: In flat mode each data-port write increments the selected address register by one.
- R6: Writing an address register with a value above 0xFFFF whose top byte is marked void (default indices 0x30 and 0x31) produces a pipe write of zero to that index with no data-port write; a non-void pipe address produces no pipe write.
- R7: A pipe write to index 0x22 emits a memory write of the data at the 64-bit address {pipe 0x21, pipe 0x20}; the address then advances by 4 with carry from the low word into the high word.
- R8: The read port returns zero for index 0 and for the data-port index, and the last written value for any other index.
- R9: After reset all write strobes are low and both address registers read zero.
- R10: Every output write is a one-cycle pulse in the cycle after the triggering bus write; at most one of the flat-space and pipe strobes is high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | General register write strobe |
| regWrIdx | input | 5 | General register write index |
| regWrData | input | 32 | General register write value |
| regRdIdx | input | 5 | General register read index |
| regRdData | output | 32 | General register read value (combinational) |
| spaceWrEn | output | 1 | Flat register space write strobe |
| spaceWrAddr | output | 16 | Flat register space write address |
| spaceWrData | output | 32 | Flat register space write value |
| pipeWrEn | output | 1 | Pipe register write strobe |
| pipeWrIdx | output | 8 | Pipe register index |
| pipeWrData | output | 32 | Pipe register write value |
| memWrEn | output | 1 | Memory dword write strobe |
| memWrAddr | output | 64 | Memory byte address |
| memWrData | output | 32 | Memory dword value |

## Verification
The one case where two of the block's functions coincide is a data-port write in pipe mode aimed at the stream-data index: in one cycle the selected address register must step (or hold, with bit 18) while the 64-bit stream address advances by four and the memory write goes out at the old stream address. The bench provokes it with a stream low word of 0xFFFFFFFC, so the same write also carries into the high word, and judges it by the memory address of that write and of the next one together with the read-back address register. A void pipe address fires a pipe write from an address-register write alone, and the bench checks that it coincides with no flat-space strobe.

// File: rtl/adp_pkg.sv
package adp_pkg;

  // Strobes decoded by the control for one bus write.
  typedef struct packed {
    logic gprWr;      // plain storage write
    logic addrWr;     // write to an address register
    logic addrUser;   // the address register written is the user one
    logic spaceWr;    // data write in flat mode
    logic pipeWr;     // data write in pipe mode
    logic pipeVoid;   // address write selecting a void pipe index
    logic bumpPlain;  // step selected address by one
    logic bumpPipe;   // step selected address top byte
  } adp_strobe_t;

endpackage

// File: rtl/adp_ctrl.sv
module adp_ctrl
  import adp_pkg::*;
#(
  parameter int NUM_GPR = 32,
  parameter int ADDR_IDX = 28,
  parameter int USR_IDX = 29,
  parameter int DATA_IDX = 30,
  parameter int SPACE_AW = 16,
  parameter int FREEZE_BIT = 18,
  parameter logic [255:0] VOID_MASK = 256'd3 << 48,
  localparam int IDX_W = $clog2(NUM_GPR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  input  logic [31:0]      selAddr,
  output logic             useUser,
  output adp_strobe_t      strb
);

  localparam logic [31:0] LEGAL_PIPE = 32'hFF00_0000 | (32'd1 << FREEZE_BIT);

  logic isAddrWr;
  logic isDataWr;
  logic selPipe;
  logic newPipe;

  assign isAddrWr = wrEn && ((wrIdx == IDX_W'(ADDR_IDX)) || (wrIdx == IDX_W'(USR_IDX)));
  assign isDataWr = wrEn && (wrIdx == IDX_W'(DATA_IDX));
  assign selPipe  = |selAddr[31:SPACE_AW];
  assign newPipe  = |wrData[31:SPACE_AW];

  always_comb begin
    strb           = '0;
    strb.addrWr    = isAddrWr;
    strb.addrUser  = (wrIdx == IDX_W'(USR_IDX));
    strb.pipeVoid  = isAddrWr && newPipe && VOID_MASK[wrData[31:24]];
    strb.spaceWr   = isDataWr && !selPipe;
    strb.bumpPlain = isDataWr && !selPipe;
    strb.pipeWr    = isDataWr && selPipe;
    strb.bumpPipe  = isDataWr && selPipe && !selAddr[FREEZE_BIT];
    strb.gprWr     = wrEn && !isAddrWr && !isDataWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         useUser <= 1'b0;
    else if (isAddrWr) useUser <= strb.addrUser;
  end

  // R3
  pipe_addr_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pipeWr |-> ((selAddr & ~LEGAL_PIPE) == 32'd0));

  // R1
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAddrWr |=> (useUser == $past(wrIdx == IDX_W'(USR_IDX))));

  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.gprWr, strb.addrWr, strb.spaceWr, strb.pipeWr}));

endmodule

// File: rtl/adp_datapath.sv
module adp_datapath
  import adp_pkg::*;
#(
  parameter int NUM_GPR = 32,
  parameter int ADDR_IDX = 28,
  parameter int USR_IDX = 29,
  parameter int DATA_IDX = 30,
  parameter int SPACE_AW = 16,
  parameter logic [7:0] STRM_LO_IDX = 8'h20,
  parameter logic [7:0] STRM_DATA_IDX = 8'h22,
  localparam int IDX_W = $clog2(NUM_GPR),
  localparam logic [7:0] STRM_HI_IDX = STRM_LO_IDX + 8'd1
) (
  input  logic                clk,
  input  logic                rstN,
  input  adp_strobe_t         strb,
  input  logic                useUser,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [31:0]         wrData,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [31:0]         rdData,
  output logic [31:0]         selAddr,
  output logic                spaceWrEn,
  output logic [SPACE_AW-1:0] spaceWrAddr,
  output logic [31:0]         spaceWrData,
  output logic                pipeWrEn,
  output logic [7:0]          pipeWrIdx,
  output logic [31:0]         pipeWrData,
  output logic                memWrEn,
  output logic [63:0]         memWrAddr,
  output logic [31:0]         memWrData
);

  logic [31:0]      gprQ [NUM_GPR];
  logic [IDX_W-1:0] selIdx;
  logic [31:0]      nextSel;
  logic             pipeFire;
  logic [7:0]       pipeIdx;
  logic [31:0]      pipeVal;
  logic [63:0]      streamAddr;

  assign selIdx  = useUser ? IDX_W'(USR_IDX) : IDX_W'(ADDR_IDX);
  assign selAddr = gprQ[selIdx];
  assign nextSel = strb.bumpPipe ? selAddr + 32'h0100_0000 : selAddr + 32'd1;

  assign rdData = ((rdIdx == '0) || (rdIdx == IDX_W'(DATA_IDX))) ? 32'd0 : gprQ[rdIdx];

  // General register file, address registers included.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_GPR; i++) gprQ[i] <= '0;
    end else if (strb.gprWr || strb.addrWr) begin
      gprQ[wrIdx] <= wrData;
    end else if (strb.bumpPlain || strb.bumpPipe) begin
      gprQ[selIdx] <= nextSel;
    end
  end

  // Pipe target: a void index fires from the address write itself.
  assign pipeFire = strb.pipeWr || strb.pipeVoid;
  assign pipeIdx  = strb.pipeVoid ? wrData[31:24] : selAddr[31:24];
  assign pipeVal  = strb.pipeVoid ? 32'd0 : wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      streamAddr <= '0;
    end else if (pipeFire) begin
      if (pipeIdx == STRM_LO_IDX)        streamAddr[31:0]  <= pipeVal;
      else if (pipeIdx == STRM_HI_IDX)   streamAddr[63:32] <= pipeVal;
      else if (pipeIdx == STRM_DATA_IDX) streamAddr        <= streamAddr + 64'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spaceWrEn   <= 1'b0;
      spaceWrAddr <= '0;
      spaceWrData <= '0;
      pipeWrEn    <= 1'b0;
      pipeWrIdx   <= '0;
      pipeWrData  <= '0;
      memWrEn     <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
    end else begin
      spaceWrEn <= strb.spaceWr;
      pipeWrEn  <= pipeFire;
      memWrEn   <= pipeFire && (pipeIdx == STRM_DATA_IDX);
      if (strb.spaceWr) begin
        spaceWrAddr <= selAddr[SPACE_AW-1:0];
        spaceWrData <= wrData;
      end
      if (pipeFire) begin
        pipeWrIdx  <= pipeIdx;
        pipeWrData <= pipeVal;
      end
      if (pipeFire && (pipeIdx == STRM_DATA_IDX)) begin
        memWrAddr <= streamAddr;
        memWrData <= pipeVal;
      end
    end
  end

  // R5
  plain_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bumpPlain |=> (selAddr == $past(selAddr) + 32'd1));

  // R4
  pipe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pipeWr && !strb.bumpPipe) |=> $stable(selAddr));

  // R7
  stream_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (streamAddr == memWrAddr + 64'd4));

  // R7
  mem_has_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (pipeWrEn && (pipeWrIdx == STRM_DATA_IDX) && (pipeWrData == memWrData)));

  // R10
  out_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({spaceWrEn, pipeWrEn}));

endmodule

// File: rtl/adp_port.sv
module adp_port
  import adp_pkg::*;
#(
  parameter int NUM_GPR = 32,
  parameter int ADDR_IDX = 28,
  parameter int USR_IDX = 29,
  parameter int DATA_IDX = 30,
  parameter int SPACE_AW = 16,
  parameter int FREEZE_BIT = 18,
  parameter logic [7:0] STRM_LO_IDX = 8'h20,
  parameter logic [7:0] STRM_DATA_IDX = 8'h22,
  parameter logic [255:0] VOID_MASK = 256'd3 << 48,
  localparam int IDX_W = $clog2(NUM_GPR)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [IDX_W-1:0]    regWrIdx,
  input  logic [31:0]         regWrData,
  input  logic [IDX_W-1:0]    regRdIdx,
  output logic [31:0]         regRdData,
  output logic                spaceWrEn,
  output logic [SPACE_AW-1:0] spaceWrAddr,
  output logic [31:0]         spaceWrData,
  output logic                pipeWrEn,
  output logic [7:0]          pipeWrIdx,
  output logic [31:0]         pipeWrData,
  output logic                memWrEn,
  output logic [63:0]         memWrAddr,
  output logic [31:0]         memWrData
);

  adp_strobe_t strb;
  logic        useUser;
  logic [31:0] selAddr;

  adp_ctrl #(
    .NUM_GPR(NUM_GPR), .ADDR_IDX(ADDR_IDX), .USR_IDX(USR_IDX),
    .DATA_IDX(DATA_IDX), .SPACE_AW(SPACE_AW), .FREEZE_BIT(FREEZE_BIT),
    .VOID_MASK(VOID_MASK)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrIdx(regWrIdx),
    .wrData(regWrData), .selAddr(selAddr), .useUser(useUser), .strb(strb)
  );

  adp_datapath #(
    .NUM_GPR(NUM_GPR), .ADDR_IDX(ADDR_IDX), .USR_IDX(USR_IDX),
    .DATA_IDX(DATA_IDX), .SPACE_AW(SPACE_AW),
    .STRM_LO_IDX(STRM_LO_IDX), .STRM_DATA_IDX(STRM_DATA_IDX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .useUser(useUser),
    .wrIdx(regWrIdx), .wrData(regWrData), .rdIdx(regRdIdx), .rdData(regRdData),
    .selAddr(selAddr),
    .spaceWrEn(spaceWrEn), .spaceWrAddr(spaceWrAddr), .spaceWrData(spaceWrData),
    .pipeWrEn(pipeWrEn), .pipeWrIdx(pipeWrIdx), .pipeWrData(pipeWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

endmodule

// File: tb/test_adp_port.sv
module test_adp_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_IDX = 5'd28;
  localparam logic [4:0] U_IDX = 5'd29;
  localparam logic [4:0] D_IDX = 5'd30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regWrIdx = '0;
  logic [31:0] regWrData = '0;
  logic [4:0]  regRdIdx = '0;
  logic [31:0] regRdData;
  logic        spaceWrEn;
  logic [15:0] spaceWrAddr;
  logic [31:0] spaceWrData;
  logic        pipeWrEn;
  logic [7:0]  pipeWrIdx;
  logic [31:0] pipeWrData;
  logic        memWrEn;
  logic [63:0] memWrAddr;
  logic [31:0] memWrData;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adp_port i_adp_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .regRdIdx(regRdIdx), .regRdData(regRdData),
    .spaceWrEn(spaceWrEn), .spaceWrAddr(spaceWrAddr), .spaceWrData(spaceWrData),
    .pipeWrEn(pipeWrEn), .pipeWrIdx(pipeWrIdx), .pipeWrData(pipeWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // One bus write; returns just after the negedge following the capturing edge.
  task automatic busWr(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrIdx = idx; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string what, input logic [4:0] idx, input logic [31:0] exp);
    regRdIdx = idx;
    #1;
    chk(what, {32'd0, regRdData}, {32'd0, exp});
  endtask

  task automatic testReset();
    chk("R9 spaceWrEn", {63'd0, spaceWrEn}, 64'd0);
    chk("R9 pipeWrEn", {63'd0, pipeWrEn}, 64'd0);
    chk("R9 memWrEn", {63'd0, memWrEn}, 64'd0);
    rdChk("R9 normal addr", A_IDX, 32'd0);
    rdChk("R9 user addr", U_IDX, 32'd0);
  endtask

  task automatic testPlain();
    busWr(A_IDX, 32'h0000_0100);
    rdChk("R1 normal addr stored", A_IDX, 32'h100);
    busWr(D_IDX, 32'hAAAA_0001);
    chk("R2 flat strobe", {63'd0, spaceWrEn}, 64'd1);
    chk("R2 flat addr", {48'd0, spaceWrAddr}, 64'h100);
    chk("R2 flat data", {32'd0, spaceWrData}, 64'hAAAA_0001);
    chk("R2 no pipe in flat", {63'd0, pipeWrEn}, 64'd0);
    busWr(D_IDX, 32'hAAAA_0002);
    chk("R5 flat step addr", {48'd0, spaceWrAddr}, 64'h101);
    rdChk("R5 addr after two", A_IDX, 32'h102);
    @(negedge clk);
    chk("R10 pulse ends", {63'd0, spaceWrEn}, 64'd0);
  endtask

  task automatic testUser();
    busWr(U_IDX, 32'h0000_0200);
    busWr(D_IDX, 32'h1111_2222);
    chk("R1 user selected", {48'd0, spaceWrAddr}, 64'h200);
    rdChk("R1 normal untouched", A_IDX, 32'h102);
    rdChk("R5 user stepped", U_IDX, 32'h201);
    busWr(A_IDX, 32'h0000_0050);
    busWr(D_IDX, 32'h3333_4444);
    chk("R1 normal reselected", {48'd0, spaceWrAddr}, 64'h50);
    rdChk("R1 user unchanged", U_IDX, 32'h201);
  endtask

  task automatic testPipeStep();
    busWr(A_IDX, 32'h2000_0000);
    chk("R6 non-void no pipe", {63'd0, pipeWrEn}, 64'd0);
    busWr(D_IDX, 32'h0000_1000);
    chk("R2 pipe strobe", {63'd0, pipeWrEn}, 64'd1);
    chk("R2 pipe idx", {56'd0, pipeWrIdx}, 64'h20);
    chk("R2 pipe data", {32'd0, pipeWrData}, 64'h1000);
    chk("R10 no flat in pipe", {63'd0, spaceWrEn}, 64'd0);
    rdChk("R4 top byte step", A_IDX, 32'h2100_0000);
    busWr(D_IDX, 32'h0000_0000);
    chk("R4 next pipe idx", {56'd0, pipeWrIdx}, 64'h21);
    busWr(D_IDX, 32'h0000_DEAD);
    chk("R7 mem strobe", {63'd0, memWrEn}, 64'd1);
    chk("R7 mem addr", memWrAddr, 64'h1000);
    chk("R7 mem data", {32'd0, memWrData}, 64'hDEAD);
    rdChk("R4 addr after three", A_IDX, 32'h2300_0000);
  endtask

  task automatic testFreeze();
    busWr(A_IDX, 32'h2204_0000);
    busWr(D_IDX, 32'h0000_0001);
    chk("R7 stream +4", memWrAddr, 64'h1004);
    busWr(D_IDX, 32'h0000_0002);
    chk("R7 stream +8", memWrAddr, 64'h1008);
    chk("R4 frozen idx", {56'd0, pipeWrIdx}, 64'h22);
    rdChk("R4 frozen addr", A_IDX, 32'h2204_0000);
  endtask

  task automatic testCarry();
    busWr(A_IDX, 32'h2000_0000);
    busWr(D_IDX, 32'hFFFF_FFFC);
    busWr(D_IDX, 32'h0000_0005);
    busWr(A_IDX, 32'h2204_0000);
    busWr(D_IDX, 32'h0000_000A);
    chk("R7 mem at carry edge", memWrAddr, 64'h5_FFFF_FFFC);
    rdChk("R4 frozen during stream", A_IDX, 32'h2204_0000);
    busWr(D_IDX, 32'h0000_000B);
    chk("R7 carry into high", memWrAddr, 64'h6_0000_0000);
    chk("R7 carry data", {32'd0, memWrData}, 64'hB);
  endtask

  task automatic testVoid();
    busWr(U_IDX, 32'h3000_0000);
    chk("R6 void fires", {63'd0, pipeWrEn}, 64'd1);
    chk("R6 void idx", {56'd0, pipeWrIdx}, 64'h30);
    chk("R6 void zero", {32'd0, pipeWrData}, 64'd0);
    chk("R6 void no flat", {63'd0, spaceWrEn}, 64'd0);
    chk("R6 void no mem", {63'd0, memWrEn}, 64'd0);
    rdChk("R6 addr kept", U_IDX, 32'h3000_0000);
    busWr(A_IDX, 32'h3100_0000);
    chk("R6 void second idx", {56'd0, pipeWrIdx}, 64'h31);
    busWr(A_IDX, 32'h3200_0000);
    chk("R6 non-void quiet", {63'd0, pipeWrEn}, 64'd0);
  endtask

  task automatic testRead();
    busWr(5'd0, 32'h1234_5678);
    rdChk("R8 index 0 zero", 5'd0, 32'd0);
    busWr(5'd5, 32'hCAFE_F00D);
    rdChk("R8 plain reg", 5'd5, 32'hCAFE_F00D);
    rdChk("R8 data port reads zero", D_IDX, 32'd0);
    chk("R8 plain write no strobe", {62'd0, spaceWrEn, pipeWrEn}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testUser();
    testPipeStep();
    testFreeze();
    testCarry();
    testVoid();
    testRead();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule